// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

A memory-mapped watchdog built around a down-counter that advances on a count-tick strobe. The counter is synchronous to the bus clock. Software sets a reload value, then enables counting and, optionally, the reset stage. Each time the counter runs out, it reloads itself. The first run-out raises an interrupt. If the counter runs out again before software has cleared that interrupt, and the reset stage is enabled, a system reset request is raised and held.

Software refreshes the watchdog by rewriting the reload value, or by writing the interrupt-clear register. Both put the counter back to its full value at once. Every register that can change the watchdog's behaviour sits behind a lock. Only a 32-bit key written to the lock register opens the lock. Writing any other value to the lock register closes it again.

With a count tick of 32768 Hz and a reload of 32768 × 128, each countdown lasts about 128 s. The reset therefore follows roughly 256 s after the last refresh.

Top module: `wdt_top`

## Requirements
- R1: After rst_ni is released, the lock is open (the lock register reads 0), the control and interrupt status registers read 0, and both irq_o and sys_rst_o are low.
- R2: A write of 0x1ACCE551 to the lock register (offset 0xC00) opens the lock. A write of any other value closes it. The lock register reads 1 when closed and 0 when open.
- R3: While the lock is closed, writes to the reload (0x000), control (0x008) and interrupt-clear (0x00C) registers leave every register, the counter and both outputs unchanged.
- R4: A write to the reload register while the lock is open stores the value and loads the counter with it on the same clock edge. The counter reads back at offset 0x004.
- R5: While control bit 0 is set, the counter drops by one on each clock with tick_i high. While control bit 0 is clear, ticks leave the counter unchanged.
- R6: A tick that finds the counter at 0 is an expiry. An expiry reloads the counter from the reload register and sets the pending flag. The pending flag reads back at offset 0x010 bit 0. irq_o equals the pending flag ANDed with control bit 0.
- R7: An expiry that finds the pending flag set while control bit 1 is set drives sys_rst_o high. sys_rst_o then stays high, whatever the bus does, until rst_ni is asserted.
- R8: With control bit 1 clear, repeated expiries never raise sys_rst_o.
- R9: A write of any value to the interrupt-clear register while the lock is open clears the pending flag and reloads the counter from the reload register.
- R10: When a reload or interrupt-clear write and a tick fall in the same cycle, the write wins. The counter takes the reloaded value, and no expiry occurs.
- R11: Reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-tick strobe, one clock wide per count |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | First-stage interrupt |
| sys_rst_o | output | 1 | Second-stage reset request, sticky |

## Verification
The hardest case to reach from the ports is a second expiry that finds the pending flag still set. Reaching it needs a tiny reload value, the reset stage enabled, and no clear between the two run-outs. The bench loads a reload of 1, so each period is two ticks, and issues single-tick strobes. It checks sys_rst_o low after the third tick and high after the fourth. The same-cycle collision between a write and an expiry is forced by draining the counter to 0, then raising tick_i in the very cycle of a reload write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] OFF_RELOAD = 12'h000;
  localparam logic [AW-1:0] OFF_COUNT  = 12'h004;
  localparam logic [AW-1:0] OFF_CTRL   = 12'h008;
  localparam logic [AW-1:0] OFF_ICLR   = 12'h00C;
  localparam logic [AW-1:0] OFF_STAT   = 12'h010;
  localparam logic [AW-1:0] OFF_LOCK   = 12'hC00;
  localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdt_lock.sv
module wdt_lock
  import wdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          open_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   open_q <= 1'b1;
    else if (wr_i) open_q <= (wdata_i == UNLOCK_KEY);
  end

  assign open_o = open_q;

  assert_key_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == UNLOCK_KEY) |=> open_o);
  assert_other_closes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i != UNLOCK_KEY) |=> !open_o);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          rst_en_i,
  input  logic          load_i,
  input  logic          clr_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] cnt_o,
  output logic          pend_o,
  output logic          sys_rst_o
);
  logic [CW-1:0] cnt_q;
  logic          pend_q, rst_q;
  logic          step, expire;

  // bus writes take priority over counting
  assign step   = tick_i && run_i && !load_i;
  assign expire = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (load_i)      cnt_q <= load_val_i;
      else if (expire) cnt_q <= reload_i;
      else if (step)   cnt_q <= cnt_q - 1'b1;

      if (clr_i)       pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;

      if (expire && pend_q && rst_en_i) rst_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign pend_o    = pend_q;
  assign sys_rst_o = rst_q;

  assert_hold_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
  assert_rst_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> rst_q);
  assert_rst_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(pend_q && rst_en_i && run_i));
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)) && !$rose(pend_q));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          sys_rst_o
);
  logic          wr, open;
  logic          wr_lock, wr_reload, wr_ctrl, wr_iclr;
  logic [DW-1:0] reload_q, cnt;
  ctrl_t         ctrl_q;
  logic          pend;

  assign wr        = req_i && we_i;
  assign wr_lock   = wr && (addr_i == OFF_LOCK);
  assign wr_reload = wr && open && (addr_i == OFF_RELOAD);
  assign wr_ctrl   = wr && open && (addr_i == OFF_CTRL);
  assign wr_iclr   = wr && open && (addr_i == OFF_ICLR);

  wdt_lock u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_lock),
    .wdata_i (wdata_i),
    .open_o  (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata_i;
      if (wr_ctrl)   ctrl_q   <= ctrl_t'(wdata_i[1:0]);
    end
  end

  wdt_core #(.CW(DW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (ctrl_q.run),
    .rst_en_i   (ctrl_q.rst_en),
    .load_i     (wr_reload || wr_iclr),
    .clr_i      (wr_iclr),
    .load_val_i (wr_reload ? wdata_i : reload_q),
    .reload_i   (reload_q),
    .cnt_o      (cnt),
    .pend_o     (pend),
    .sys_rst_o  (sys_rst_o)
  );

  assign irq_o = pend && ctrl_q.run;

  always_comb begin
    unique case (addr_i)
      OFF_RELOAD: rdata_o = reload_q;
      OFF_COUNT:  rdata_o = cnt;
      OFF_CTRL:   rdata_o = {{(DW-2){1'b0}}, ctrl_q};
      OFF_STAT:   rdata_o = {{(DW-1){1'b0}}, pend};
      OFF_LOCK:   rdata_o = {{(DW-1){1'b0}}, !open};
      default:    rdata_o = '0;
    endcase
  end

  assert_locked_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open && wr) |=> $stable(reload_q) && $stable(ctrl_q) && $stable(pend));
  assert_irq_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend && ctrl_q.run));
endmodule

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_o, sys_rst_o;
  int          n_chk = 0, n_fail = 0;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #5 clk_i = ~clk_i;

  wdt_top dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic tk = 1'b0);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; tick_i = tk;
    @(negedge clk_i);
    req_i = 0; we_i = 0; tick_i = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1;
      @(negedge clk_i); tick_i = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'hC00, d); chk("R1 lock", d, 0);
    rd(12'h008, d); chk("R1 ctrl", d, 0);
    rd(12'h010, d); chk("R1 stat", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 rst", sys_rst_o, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    wr(12'h000, 5);
    rd(12'h004, d); chk("R4 load", d, 5);
    wr(12'h008, 1);
    ticks(2);
    rd(12'h004, d); chk("R5 count", d, 3);
    wr(12'h008, 0);
    ticks(3);
    rd(12'h004, d); chk("R5 frozen", d, 3);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(12'hC00, 0);
    rd(12'hC00, d); chk("R2 closed", d, 1);
    wr(12'h000, 9);
    wr(12'h008, 3);
    rd(12'h000, d); chk("R3 reload", d, 5);
    rd(12'h004, d); chk("R3 count", d, 3);
    rd(12'h008, d); chk("R3 ctrl", d, 0);
    wr(12'hC00, KEY);
    rd(12'hC00, d); chk("R2 open", d, 0);
    wr(12'hC00, KEY ^ 32'h1);
    rd(12'hC00, d); chk("R2 near key", d, 1);
    wr(12'hC00, KEY);
  endtask

  task automatic t_expire();
    logic [31:0] d;
    wr(12'h000, 2);
    wr(12'h008, 1);
    ticks(2);
    rd(12'h010, d); chk("R6 no early", d, 0);
    ticks(1);
    rd(12'h004, d); chk("R6 reload", d, 2);
    rd(12'h010, d); chk("R6 stat", d, 1);
    chk("R6 irq", irq_o, 1);
    ticks(3);
    chk("R8 no rst", sys_rst_o, 0);
    // closed lock must not clear
    wr(12'hC00, 0);
    wr(12'h00C, 0);
    rd(12'h010, d); chk("R3 iclr", d, 1);
    wr(12'hC00, KEY);
    ticks(1);
    wr(12'h00C, 0);
    rd(12'h010, d); chk("R9 stat", d, 0);
    chk("R9 irq", irq_o, 0);
    rd(12'h004, d); chk("R9 reload", d, 2);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    ticks(2);
    rd(12'h004, d); chk("R10 at zero", d, 0);
    wr(12'h000, 7, 1'b1);
    rd(12'h004, d); chk("R10 count", d, 7);
    rd(12'h010, d); chk("R10 no expiry", d, 0);
    rd(12'h020, d); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_reset_stage();
    logic [31:0] d;
    wr(12'h000, 1);
    wr(12'h008, 3);
    ticks(3);
    chk("R7 not yet", sys_rst_o, 0);
    ticks(1);
    chk("R7 rst", sys_rst_o, 1);
    wr(12'h00C, 0);
    wr(12'h008, 0);
    wr(12'hC00, 0);
    ticks(2);
    chk("R7 sticky", sys_rst_o, 1);
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    chk("R1 rst cleared", sys_rst_o, 0);
    rd(12'hC00, d); chk("R1 lock reopen", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        t_reset();
        t_count();
        t_lock();
        t_expire();
        t_collide();
        t_reset_stage();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule